// File: doc/BRIEF.md
# Direct-Mapped Cache with Block Fill and Early Restart

This block is a direct-mapped cache that sits between a processor issuing 15-bit word addresses with 12-bit data words and a slower main memory. It holds 512 words as 64 blocks of 8 words. Each block keeps one tag, shared by its eight words, and one valid bit. A read that hits is answered from the on-chip arrays without touching main memory.

A read that misses fetches the whole 8-word block. The fill always starts at word 0 of the block and runs in order. The requested word is handed to the processor in the cycle after it arrives, without waiting for the rest of the block. The processor stays stalled through `cpu_busy` until the last word of the block has been written.

Writes go straight to main memory. A write that hits also updates the cached copy. A write that misses leaves the cache untouched, so it allocates no block.

Top module: `dmc_cache`

## Requirements
- R1: The address splits as tag = `addr[14:9]`, block = `addr[8:3]` and word = `addr[2:0]`. A read whose block is valid and holds the same tag returns the cached word with `cpu_rvalid` two cycles after acceptance, and it raises no main-memory request.
- R2: After reset, `cpu_busy`, `cpu_rvalid` and `mem_req` are 0 and every block is invalid, so the first read of any block misses.
- R3: A read miss issues exactly one memory read, with `mem_we`=0 and `mem_addr` = {tag, block, 3'b000}. The 8 returned words (word 0 first) are stored, and afterwards every word of that block hits with the memory's value.
- R4: On a read miss, `cpu_rvalid` carries the requested word in the cycle after the beat that delivered it. `cpu_busy` stays 1 until the cycle after the eighth beat.
- R5: A read miss whose tag differs from the stored tag replaces that block, so a later read with the old tag misses again.
- R6: Every write issues one memory write with `mem_we`=1, the full address and the write data. `cpu_busy` drops in the cycle after `mem_ack`.
- R7: A write hit also updates the cached word, and a later read of it hits and returns the new data.
- R8: A write miss does not fill or allocate a block, and a later read of the same address misses.
- R9: `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. A `cpu_req` presented while `cpu_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, accepted when `cpu_busy` is 0 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address |
| cpu_wdata | input | 12 | Write data |
| cpu_busy | output | 1 | Request in progress; processor must wait |
| cpu_rvalid | output | 1 | One-cycle pulse: `cpu_rdata` holds the read word |
| cpu_rdata | output | 12 | Read data |
| mem_req | output | 1 | Main-memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = block fill |
| mem_addr | output | 15 | Memory address (block-aligned for fills) |
| mem_wdata | output | 12 | Memory write data |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | 12 | Fill beat data |

## Verification
The bench targets several corner cases, and each has a distinct way of going wrong:
- Reads of word 0 and word 7 during a fill. A design that answered only at the end of the fill would show `cpu_rvalid` after `cpu_busy` falls. A design with the beat count off by one would return a neighbouring word.
- A write hit followed by a read. A design that did not update the cached word on a write would return stale data on that read.
- A write miss followed by a read. A design that allocated on a write miss would hit on that read instead of filling.
- Tag aliasing between addresses that share a block number. A design that compared too few tag bits would hit on the wrong tag.
- A request held high during a fill. A design that accepted work while busy would leave an extra memory write behind.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEMWAIT,
    ST_FILL
  } dmc_state_e;
endpackage

// File: rtl/dmc_sdp_ram.sv
module dmc_sdp_ram #(
  parameter int AW = 9,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmc_valid_array.sv
module dmc_valid_array #(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_q
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
      rd_q <= 1'b0;
    end else begin
      if (set_en) bits[set_idx] <= 1'b1;
      if (rd_en)  rd_q <= bits[rd_idx];
    end
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int BLK_W  = 6,
  parameter int OFS_W  = 3,
  parameter int DATA_W = 12,
  localparam int ADDR_W = TAG_W + BLK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = BLK_W + OFS_W;
  localparam logic [OFS_W-1:0] LAST_BEAT = {OFS_W{1'b1}};

  dmc_state_e state;

  logic              lat_we;
  logic [TAG_W-1:0]  lat_tag;
  logic [BLK_W-1:0]  lat_blk;
  logic [OFS_W-1:0]  lat_ofs;
  logic [DATA_W-1:0] lat_wdata;
  logic [OFS_W-1:0]  beat_cnt;

  logic              accept;
  logic [IDX_W-1:0]  rd_idx;
  logic              hit;
  logic              vld_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  logic              dat_we;
  logic [IDX_W-1:0]  dat_waddr;
  logic [DATA_W-1:0] dat_wdata;
  logic              fill_last;

  assign accept = cpu_req && !cpu_busy && (state == ST_IDLE);
  assign rd_idx = cpu_addr[IDX_W-1:0];
  assign hit    = vld_q && (tag_q == lat_tag);
  assign fill_last = (state == ST_FILL) && mem_rvalid && (beat_cnt == LAST_BEAT);

  always_comb begin
    dat_we    = 1'b0;
    dat_waddr = {lat_blk, lat_ofs};
    dat_wdata = lat_wdata;
    if (state == ST_LOOKUP && lat_we && hit) begin
      dat_we = 1'b1;
    end else if (state == ST_FILL && mem_rvalid) begin
      dat_we    = 1'b1;
      dat_waddr = {lat_blk, beat_cnt};
      dat_wdata = mem_rdata;
    end
  end

  dmc_sdp_ram #(.AW(IDX_W), .DW(DATA_W)) u_data (
    .clk   (clk),
    .we    (dat_we),
    .waddr (dat_waddr),
    .wdata (dat_wdata),
    .re    (accept),
    .raddr (rd_idx),
    .rdata (data_q)
  );

  dmc_sdp_ram #(.AW(BLK_W), .DW(TAG_W)) u_tag (
    .clk   (clk),
    .we    (fill_last),
    .waddr (lat_blk),
    .wdata (lat_tag),
    .re    (accept),
    .raddr (rd_idx[IDX_W-1:OFS_W]),
    .rdata (tag_q)
  );

  dmc_valid_array #(.BLK_W(BLK_W)) u_vld (
    .clk     (clk),
    .rst     (rst),
    .set_en  (fill_last),
    .set_idx (lat_blk),
    .rd_en   (accept),
    .rd_idx  (rd_idx[IDX_W-1:OFS_W]),
    .rd_q    (vld_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cpu_busy   <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      lat_we     <= 1'b0;
      lat_tag    <= '0;
      lat_blk    <= '0;
      lat_ofs    <= '0;
      lat_wdata  <= '0;
      beat_cnt   <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            lat_we    <= cpu_we;
            lat_tag   <= cpu_addr[ADDR_W-1:IDX_W];
            lat_blk   <= cpu_addr[IDX_W-1:OFS_W];
            lat_ofs   <= cpu_addr[OFS_W-1:0];
            lat_wdata <= cpu_wdata;
            cpu_busy  <= 1'b1;
            state     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (!lat_we && hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= data_q;
            cpu_busy   <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= lat_we;
            mem_addr  <= lat_we ? {lat_tag, lat_blk, lat_ofs}
                                : {lat_tag, lat_blk, {OFS_W{1'b0}}};
            mem_wdata <= lat_wdata;
            beat_cnt  <= '0;
            state     <= ST_MEMWAIT;
          end
        end
        ST_MEMWAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_we) begin
              mem_we   <= 1'b0;
              cpu_busy <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_rvalid) begin
            beat_cnt <= beat_cnt + 1'b1;
            if (beat_cnt == lat_ofs) begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= mem_rdata;
            end
            if (beat_cnt == LAST_BEAT) begin
              cpu_busy <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[2:0] == 3'b000)); // R3

  AST_RVALID_IN_OP: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(cpu_busy)); // R4

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_busy); // R6

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req); // R9
endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(15)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_busy   (cpu_busy),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack)
);

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we;
  logic [14:0] cpu_addr;
  logic [11:0] cpu_wdata;
  logic        cpu_busy, cpu_rvalid;
  logic [11:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata;
  logic        mem_ack, mem_rvalid;
  logic [11:0] mem_rdata;

  always #2 clk = ~clk;

  dmc_cache u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] mmem [0:2047];
  int          n_fill = 0, n_wr = 0, n_beats = 0;
  logic [14:0] last_fill_addr, last_wr_addr;
  logic [11:0] last_wr_data;

  bit          cv [0:63];
  logic [5:0]  ct [0:63];

  function automatic int midx(input logic [14:0] a);
    return int'({a[10:9], a[8:0]});
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // main-memory responder
  initial begin
    logic [14:0] wa;
    logic        wwe;
    logic [11:0] wd;
    mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_ack = 1'b1;
        wa = mem_addr; wwe = mem_we; wd = mem_wdata;
        @(negedge clk);
        mem_ack = 1'b0;
        if (wwe) begin
          mmem[midx(wa)] = wd;
          last_wr_addr = wa; last_wr_data = wd;
          n_wr++;
        end else begin
          last_fill_addr = wa;
          n_fill++;
          for (int k = 0; k < 8; k++) begin
            repeat ($urandom % 2) @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = mmem[midx(wa + 15'(k))];
            n_beats++;
            @(negedge clk);
            mem_rvalid = 1'b0;
          end
        end
      end
    end
  end

  task automatic issue(input bit we, input logic [14:0] a, input logic [11:0] d,
                       input bit hold);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    if (hold) begin
      cpu_we = 1'b1; cpu_wdata = 12'h5A5;
    end else begin
      cpu_req = 1'b0;
    end
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    while (cpu_busy && n < 2000) begin @(negedge clk); n++; end
    chk(!cpu_busy, rq, "busy never cleared", int'(cpu_busy), 0);
  endtask

  task automatic do_read(input logic [14:0] a, input bit hold, input string rq);
    bit  exp_miss;
    int  f0, w0, n;
    bit  busy_at;
    logic [11:0] got;
    logic [5:0] blk;
    blk = a[8:3];
    exp_miss = !cv[blk] || (ct[blk] != a[14:9]);
    f0 = n_fill; w0 = n_wr;
    issue(1'b0, a, 12'h000, hold);
    n = 0;
    while (!cpu_rvalid && n < 2000) begin @(negedge clk); n++; end
    got = cpu_rdata; busy_at = cpu_busy;
    chk(cpu_rvalid, rq, "no read response", 0, 1);
    if (hold) cpu_req = 1'b0;
    wait_idle(rq);
    chk(got == mmem[midx(a)], rq, "read data", int'(got), int'(mmem[midx(a)]));
    chk((n_fill - f0) == int'(exp_miss), rq, "fill count (hit/miss)",
        n_fill - f0, int'(exp_miss));
    if (exp_miss) begin
      chk(last_fill_addr == {a[14:3], 3'b000}, "R3", "fill address",
          int'(last_fill_addr), int'({a[14:3], 3'b000}));
      chk(n_beats % 8 == 0, "R4", "busy dropped before fill end", n_beats % 8, 0);
      if (a[2:0] != 3'd7)
        chk(busy_at, "R4", "word not forwarded early", int'(busy_at), 1);
      cv[blk] = 1'b1; ct[blk] = a[14:9];
    end
    if (hold) chk(n_wr == w0, "R9", "request while busy was taken", n_wr - w0, 0);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [11:0] d, input string rq);
    int f0, w0;
    f0 = n_fill; w0 = n_wr;
    issue(1'b1, a, d, 1'b0);
    wait_idle(rq);
    chk(n_wr == w0 + 1, "R6", "memory write count", n_wr - w0, 1);
    chk(last_wr_addr == a && last_wr_data == d, "R6", "memory write addr/data",
        int'({last_wr_addr, last_wr_data}), int'({a, d}));
    chk(n_fill == f0, "R8", "write caused a fill", n_fill - f0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) mmem[i] = 12'((i * 37 + 5) ^ (i >> 3));
    for (int i = 0; i < 64; i++) begin cv[i] = 1'b0; ct[i] = '0; end
    rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(!cpu_busy,   "R2", "busy after reset",   int'(cpu_busy), 0);
    chk(!cpu_rvalid, "R2", "rvalid after reset", int'(cpu_rvalid), 0);
    chk(!mem_req,    "R2", "mem_req after reset", int'(mem_req), 0);
    // R2 first access misses
    do_read({6'd0, 6'd0, 3'd5}, 1'b0, "R2");
    // R1/R3 all words of the block now hit
    for (int w = 0; w < 8; w++) do_read({6'd0, 6'd0, 3'(w)}, 1'b0, "R1");
    // R4/R9 word 0 forwarded early, request during fill ignored
    do_read({6'd0, 6'd1, 3'd0}, 1'b1, "R9");
    // R4 last word of block
    do_read({6'd0, 6'd2, 3'd7}, 1'b0, "R4");
    do_read({6'd0, 6'd2, 3'd6}, 1'b0, "R3");
    // R7 write hit then read
    do_write({6'd0, 6'd0, 3'd3}, 12'hABC, "R6");
    do_read({6'd0, 6'd0, 3'd3}, 1'b0, "R7");
    // R8 write miss, no allocate
    do_write({6'd1, 6'd5, 3'd2}, 12'h3C1, "R8");
    do_read({6'd1, 6'd5, 3'd2}, 1'b0, "R8");
    // R5 tag replacement on shared block
    do_read({6'd1, 6'd0, 3'd2}, 1'b0, "R5");
    do_read({6'd0, 6'd0, 3'd2}, 1'b0, "R5");
    do_read({6'd3, 6'd0, 3'd1}, 1'b0, "R5");
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      a = {4'd0, 2'($urandom % 4), 3'd0, 3'($urandom % 8), 3'($urandom % 8)};
      if ($urandom % 4 == 0) do_write(a, 12'($urandom), "R6");
      else                   do_read(a, 1'b0, "R1");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule